// File: doc/BRIEF.md
# Move and Shift Execution Unit

This unit executes the register-move family of a 32-bit processor. Each issued operation completes in one clock. A plain move copies a source operand to the destination, an inverted move writes the bitwise complement, and a wide-immediate move loads a zero-extended 16-bit constant. Plain and inverted moves share one operand shifter. The shifter supports logical left, logical right, arithmetic right, rotate right, and rotate right through carry. The shift count is taken either from a 5-bit immediate field or from the low byte of a register value.

Decode, condition evaluation and the register file live elsewhere. The unit receives three things from outside: a condition-pass bit, a set-flags request, and the current carry. The carry feeds both the zero-amount case and the through-carry rotate. The unit registers the result, a write strobe and the N, Z and C flags. The flags change only when an executed move asks for them.

Top module: `mvx_exec`

## Requirements
- R1: With opcode 0 (plain move) and condition passing, the next cycle shows `wr_o`=1 and `res_o` equal to the shifted source operand.
- R2: With opcode 1 (inverted move), `res_o` becomes the bitwise NOT of the shifted source operand.
- R3: With opcode 2 (wide move), `res_o` becomes `imm16_i` zero-extended to 32 bits. The shift inputs are ignored, and N, Z and C keep their values even when set-flags is requested.
- R4: Shift kind 0 (logical left) and kind 1 (logical right) work as follows. For amounts 1..31 the shift is normal, and the carry is the last bit shifted out. An amount of 32 gives 0 with the carry set to bit 0 (left) or bit 31 (right). Amounts above 32 give 0 with carry 0.
- R5: Shift kind 2 (arithmetic right) shifts in copies of bit 31, with the carry equal to the last bit out. Amounts of 32 or more give all copies of bit 31, with carry equal to bit 31.
- R6: Shift kind 3 (rotate right) uses the amount modulo 32, and its carry is result bit 31. Shift kind 4 (rotate through carry) ignores the amount. It outputs `{carry_i, src[31:1]}`, with new carry `src[0]`.
- R7: `amt_sel_i`=0 selects the 5-bit `amt_imm_i`; `amt_sel_i`=1 uses only bits [7:0] of `amt_reg_i`. For kinds 0–3, an amount of 0 passes the operand unchanged and keeps `carry_i` as the shifter carry.
- R8: When an executed plain or inverted move has `set_flags_i`=1, the next cycle shows N = result bit 31, Z = (result == 0), and C = the shifter carry.
- R9: Without a set-flags request, N, Z and C are unchanged.
- R10: If `issue_i` or `cond_ok_i` is 0, then next cycle `wr_o`=0, and `res_o` and the flags hold.
- R11: Opcode 3 never writes and leaves the result and flags unchanged. Shift kinds 5–7 pass the operand unchanged and keep `carry_i`.
- R12: While `rst_n` is low and right after its release, `res_o`, `wr_o`, `n_o`, `z_o` and `c_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An operation is presented this cycle |
| op_i | input | 2 | 0 move, 1 inverted move, 2 wide move, 3 reserved |
| src_i | input | 32 | Source operand before shifting |
| imm16_i | input | 16 | Constant for the wide move |
| shk_i | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 RRX, 5–7 none |
| amt_sel_i | input | 1 | 0: immediate amount, 1: register amount |
| amt_imm_i | input | 5 | Immediate shift amount |
| amt_reg_i | input | 32 | Register value holding the shift amount in bits [7:0] |
| carry_i | input | 1 | Current carry flag |
| cond_ok_i | input | 1 | Condition evaluated true |
| set_flags_i | input | 1 | Request flag update |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Destination write strobe |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| c_o | output | 1 | Carry flag |

## Verification
Every datapath and flag error surfaces at the ports one cycle after the offending issue. A wrong shift boundary, such as the 32 or above-32 cases or the modulo-32 rotate, appears as a mismatched `res_o` or `c_o` on that same following cycle. A corrupted flag-enable path shows up differently. The N, Z or C value is wrong at once, and it stays wrong on every later cycle until a flag-setting move overwrites it. That is why the bench keeps a running model of the held flags instead of checking them only after flag-setting operations. The sweep walks every opcode, shift kind, amount source and the amounts 0, 1, 31, 32, 33, 64 and 255 over several operand patterns.

// File: rtl/mvx_pkg.sv
package mvx_pkg;
  typedef enum logic [1:0] {
    OP_MOV  = 2'd0,
    OP_MVN  = 2'd1,
    OP_MOVW = 2'd2,
    OP_RSV  = 2'd3
  } mvx_op_e;

  typedef enum logic [2:0] {
    SH_LSL = 3'd0,
    SH_LSR = 3'd1,
    SH_ASR = 3'd2,
    SH_ROR = 3'd3,
    SH_RRX = 3'd4
  } mvx_shk_e;
endpackage

// File: rtl/mvx_shifter.sv
module mvx_shifter
  import mvx_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  logic [W-1:0]  x_i,
  input  logic [2:0]    kind_i,
  input  logic [AW-1:0] amt_i,
  input  logic          cin_i,
  output logic [W-1:0]  r_o,
  output logic          c_o
);
  localparam int LW = $clog2(W);
  localparam logic [AW-1:0] AMT_W = AW'(W);

  logic [W:0]     lsl_t;
  logic [W:0]     lsr_t;
  logic [W:0]     asr_t;
  logic [2*W-1:0] ror_t;
  logic [LW-1:0]  amt_lo;
  logic           amt_zero;
  logic           amt_full;
  logic           amt_over;

  assign amt_lo   = amt_i[LW-1:0];
  assign amt_zero = (amt_i == '0);
  assign amt_full = (amt_i == AMT_W);
  assign amt_over = (amt_i > AMT_W);

  always_comb begin
    lsl_t = {1'b0, x_i} << amt_lo;
    lsr_t = {x_i, 1'b0} >> amt_lo;
    asr_t = $signed({x_i, 1'b0}) >>> amt_lo;
    ror_t = {x_i, x_i} >> amt_lo;
  end

  always_comb begin
    r_o = x_i;
    c_o = cin_i;
    unique case (mvx_shk_e'(kind_i))
      SH_LSL: begin
        if (amt_over)      begin r_o = '0; c_o = 1'b0;     end
        else if (amt_full) begin r_o = '0; c_o = x_i[0];   end
        else if (!amt_zero) begin r_o = lsl_t[W-1:0]; c_o = lsl_t[W]; end
      end
      SH_LSR: begin
        if (amt_over)      begin r_o = '0; c_o = 1'b0;     end
        else if (amt_full) begin r_o = '0; c_o = x_i[W-1]; end
        else if (!amt_zero) begin r_o = lsr_t[W:1]; c_o = lsr_t[0]; end
      end
      SH_ASR: begin
        if (amt_over || amt_full) begin
          r_o = {W{x_i[W-1]}};
          c_o = x_i[W-1];
        end else if (!amt_zero) begin
          r_o = asr_t[W:1];
          c_o = asr_t[0];
        end
      end
      SH_ROR: begin
        if (!amt_zero) begin
          r_o = ror_t[W-1:0];
          c_o = ror_t[W-1];
        end
      end
      SH_RRX: begin
        r_o = {cin_i, x_i[W-1:1]};
        c_o = x_i[0];
      end
      default: begin
        r_o = x_i;
        c_o = cin_i;
      end
    endcase
  end

  // Guard the far-shift and zero-amount corners against the main path.
  always_comb begin
    if (kind_i == 3'd0 && amt_i > AMT_W)
      p_lsl_far_zero_r4: assert (r_o == '0 && c_o == 1'b0);
    if (kind_i == 3'd2 && amt_i >= AMT_W)
      p_asr_far_sign_r5: assert (r_o == {W{x_i[W-1]}} && c_o == x_i[W-1]);
    if (kind_i != 3'd4 && amt_i == '0)
      p_zero_amt_pass_r7: assert (r_o == x_i && c_o == cin_i);
  end
endmodule

// File: rtl/mvx_flagreg.sv
module mvx_flagreg (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic n_d,
  input  logic z_d,
  input  logic c_d,
  output logic n_q,
  output logic z_q,
  output logic c_q
);
  logic [2:0] flg_q;
  logic [2:0] flg_d;

  always_comb begin
    flg_d = flg_q;
    if (en_i) flg_d = {n_d, z_d, c_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign {n_q, z_q, c_q} = flg_q;
endmodule

// File: rtl/mvx_exec.sv
module mvx_exec
  import mvx_pkg::*;
#(
  parameter int W   = 32,
  parameter int AW  = 8,
  parameter int IMW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue_i,
  input  logic [1:0]     op_i,
  input  logic [W-1:0]   src_i,
  input  logic [IMW-1:0] imm16_i,
  input  logic [2:0]     shk_i,
  input  logic           amt_sel_i,
  input  logic [$clog2(W)-1:0] amt_imm_i,
  input  logic [W-1:0]   amt_reg_i,
  input  logic           carry_i,
  input  logic           cond_ok_i,
  input  logic           set_flags_i,
  output logic [W-1:0]   res_o,
  output logic           wr_o,
  output logic           n_o,
  output logic           z_o,
  output logic           c_o
);
  localparam int LW = $clog2(W);

  mvx_op_e       op;
  logic [AW-1:0] amt;
  logic [W-1:0]  sh_r;
  logic          sh_c;
  logic [W-1:0]  res_d;
  logic [W-1:0]  res_q;
  logic          wr_d;
  logic          wr_q;
  logic          exec;
  logic          writes;
  logic          flag_en;
  logic          unused_amt_hi;

  assign op            = mvx_op_e'(op_i);
  assign amt           = amt_sel_i ? amt_reg_i[AW-1:0]
                                   : {{(AW-LW){1'b0}}, amt_imm_i};
  assign unused_amt_hi = ^amt_reg_i[W-1:AW];

  mvx_shifter #(.W(W), .AW(AW)) u_shift (
    .x_i    (src_i),
    .kind_i (shk_i),
    .amt_i  (amt),
    .cin_i  (carry_i),
    .r_o    (sh_r),
    .c_o    (sh_c)
  );

  assign exec    = issue_i & cond_ok_i;
  assign writes  = exec & (op != OP_RSV);
  assign flag_en = writes & set_flags_i & (op != OP_MOVW);

  always_comb begin
    res_d = res_q;
    unique case (op)
      OP_MOV:  res_d = sh_r;
      OP_MVN:  res_d = ~sh_r;
      OP_MOVW: res_d = {{(W-IMW){1'b0}}, imm16_i};
      default: res_d = res_q;
    endcase
    wr_d = writes;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      wr_q  <= 1'b0;
    end else begin
      wr_q <= wr_d;
      if (writes) res_q <= res_d;
    end
  end

  mvx_flagreg u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (flag_en),
    .n_d   (res_d[W-1]),
    .z_d   (res_d == '0),
    .c_d   (sh_c),
    .n_q   (n_o),
    .z_q   (z_o),
    .c_q   (c_o)
  );

  assign res_o = res_q;
  assign wr_o  = wr_q;

  p_cond_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!issue_i || !cond_ok_i) |=> (!wr_o && $stable(res_o)));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_i && cond_ok_i && set_flags_i) |=> $stable({n_o, z_o, c_o}));

  p_wide_zext_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cond_ok_i && op_i == 2'd2)
      |=> (res_o[W-1:IMW] == '0 && $stable({n_o, z_o, c_o}) && wr_o));

  p_nz_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cond_ok_i && set_flags_i && op_i[1] == 1'b0)
      |=> (n_o == res_o[W-1] && z_o == (res_o == '0)));

  p_rsv_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && op_i == 2'd3)
      |=> (!wr_o && $stable(res_o) && $stable({n_o, z_o, c_o})));

  p_mvn_inverts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && cond_ok_i && op_i == 2'd1 && shk_i == 3'd5)
      |=> (res_o == ~$past(src_i)));
endmodule

// File: tb/tb_mvx_exec.sv
module tb_mvx_exec;
  localparam int W = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [1:0]  op_i;
  logic [31:0] src_i;
  logic [15:0] imm16_i;
  logic [2:0]  shk_i;
  logic        amt_sel_i;
  logic [4:0]  amt_imm_i;
  logic [31:0] amt_reg_i;
  logic        carry_i;
  logic        cond_ok_i;
  logic        set_flags_i;
  logic [31:0] res_o;
  logic        wr_o;
  logic        n_o;
  logic        z_o;
  logic        c_o;

  always #5 clk = ~clk;

  mvx_exec #(.W(W), .AW(8), .IMW(16)) dut (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i), .src_i(src_i),
    .imm16_i(imm16_i), .shk_i(shk_i), .amt_sel_i(amt_sel_i),
    .amt_imm_i(amt_imm_i), .amt_reg_i(amt_reg_i), .carry_i(carry_i),
    .cond_ok_i(cond_ok_i), .set_flags_i(set_flags_i), .res_o(res_o),
    .wr_o(wr_o), .n_o(n_o), .z_o(z_o), .c_o(c_o)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [31:0] e_res;
  logic        e_wr, e_n, e_z, e_c;

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk_all(input string rtag, input string wtag,
                         input string ftag, input string ctag);
    chk(wtag, "wr", {31'b0, wr_o}, {31'b0, e_wr});
    chk(rtag, "res", res_o, e_res);
    chk(ftag, "N", {31'b0, n_o}, {31'b0, e_n});
    chk(ftag, "Z", {31'b0, z_o}, {31'b0, e_z});
    chk(ctag, "C", {31'b0, c_o}, {31'b0, e_c});
  endtask

  function automatic void ref_shift(input logic [2:0] k, input logic [7:0] a,
                                    input logic [31:0] x, input logic c,
                                    output logic [31:0] r, output logic co);
    logic [63:0] t;
    r  = x;
    co = c;
    case (k)
      3'd0: if (a != 0) begin t = {32'b0, x} << a; r = t[31:0]; co = t[32]; end
      3'd1: if (a != 0) begin t = {x, 32'b0} >> a; r = t[63:32]; co = t[31]; end
      3'd2: if (a != 0) begin t = $signed({x, 32'b0}) >>> a; r = t[63:32]; co = t[31]; end
      3'd3: if (a != 0) begin t = {x, x} >> (a % 32); r = t[31:0]; co = r[31]; end
      3'd4: begin r = {c, x[31:1]}; co = x[0]; end
      default: ;
    endcase
  endfunction

  function automatic string shift_tag(input logic [2:0] k, input logic [7:0] a);
    if (k < 3'd4 && a == 0) return "R7";
    case (k)
      3'd0, 3'd1: return "R4";
      3'd2:       return "R5";
      3'd3, 3'd4: return "R6";
      default:    return "R11";
    endcase
  endfunction

  initial begin
    logic [31:0] pats [4];
    logic [15:0] imms [4];
    logic [7:0]  amts [7];
    pats[0] = 32'h8000_0001; pats[1] = 32'h0000_0000;
    pats[2] = 32'hFFFF_FFFF; pats[3] = 32'h7A5C_3E91;
    imms[0] = 16'hFFFF; imms[1] = 16'h0000; imms[2] = 16'h8001; imms[3] = 16'h1234;
    amts[0] = 8'd0;  amts[1] = 8'd1;  amts[2] = 8'd31; amts[3] = 8'd32;
    amts[4] = 8'd33; amts[5] = 8'd255; amts[6] = 8'd64;

    rst_n = 1'b0; issue_i = 1'b0; op_i = '0; src_i = '0; imm16_i = '0;
    shk_i = '0; amt_sel_i = 1'b0; amt_imm_i = '0; amt_reg_i = '0;
    carry_i = 1'b0; cond_ok_i = 1'b0; set_flags_i = 1'b0;
    e_res = '0; e_wr = 1'b0; e_n = 1'b0; e_z = 1'b0; e_c = 1'b0;

    repeat (3) @(negedge clk);
    chk_all("R12", "R12", "R12", "R12");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R12", "R12", "R12", "R12");

    for (int op = 0; op < 4; op++)
      for (int k = 0; k < 8; k++)
        for (int ai = 0; ai < 7; ai++)
          for (int sel = 0; sel < 2; sel++)
            for (int p = 0; p < 4; p++)
              for (int ci = 0; ci < 2; ci++)
                for (int sf = 0; sf < 2; sf++) begin
                  logic [7:0]  effa;
                  logic [31:0] sr;
                  logic        sc;
                  logic        cond;
                  logic        wrt;
                  string       rtag, wtag, ftag, ctag;
                  cond = ((p + ci + ai + k) % 5) != 4;
                  issue_i     = 1'b1;
                  op_i        = 2'(op);
                  shk_i       = 3'(k);
                  src_i       = pats[p];
                  imm16_i     = imms[p];
                  amt_sel_i   = 1'(sel);
                  amt_imm_i   = amts[ai][4:0];
                  amt_reg_i   = {24'hA5C3F0, amts[ai]};
                  carry_i     = 1'(ci);
                  set_flags_i = 1'(sf);
                  cond_ok_i   = cond;
                  effa = (sel == 1) ? amts[ai] : {3'b0, amts[ai][4:0]};
                  ref_shift(3'(k), effa, pats[p], 1'(ci), sr, sc);
                  wrt  = cond && (op != 3);
                  e_wr = wrt;
                  if (wrt) begin
                    case (op)
                      0: e_res = sr;
                      1: e_res = ~sr;
                      default: e_res = {16'b0, imms[p]};
                    endcase
                    if (sf == 1 && op != 2) begin
                      e_n = e_res[31];
                      e_z = (e_res == 32'b0);
                      e_c = sc;
                    end
                  end
                  // Tags: result by opcode, held state by the rule that holds it.
                  if (!cond) begin
                    rtag = "R10"; wtag = "R10"; ftag = "R10"; ctag = "R10";
                  end else if (op == 3) begin
                    rtag = "R11"; wtag = "R11"; ftag = "R11"; ctag = "R11";
                  end else if (op == 2) begin
                    rtag = "R3"; wtag = "R3"; ftag = "R3"; ctag = "R3";
                  end else begin
                    rtag = (op == 0) ? "R1" : "R2";
                    if (k >= 5 || (k < 4 && effa == 0)) rtag = shift_tag(3'(k), effa);
                    wtag = rtag;
                    ftag = (sf == 1) ? "R8" : "R9";
                    ctag = (sf == 1) ? shift_tag(3'(k), effa) : "R9";
                  end
                  @(negedge clk);
                  chk_all(rtag, wtag, ftag, ctag);
                end

    issue_i = 1'b0;
    e_wr = 1'b0;
    @(negedge clk);
    chk_all("R10", "R10", "R10", "R10");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog got=%h exp=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule